// File: doc/BRIEF.md
# Serpentine Tiled-Texture Pixel Address Generator

This block turns a pixel coordinate into the byte address of that pixel inside a three-level tiled texture. Each pixel is 32 bits. Pixels are grouped into 4x4 micro-tiles of 64 bytes. Sixteen micro-tiles form a 16x16-pixel subtile of 1 KB. Four subtiles form a 32x32-pixel tile of 4 KB. Tiles are stored row by row, and the direction flips on every row. Even tile rows run left to right and odd tile rows run right to left. The storage order of the four subtiles inside a tile also depends on whether the tile row is even or odd.

A request carries the pixel coordinate, the surface width counted in 4 KB tiles, and a base address. The request is accepted with a valid/ready handshake, and the address comes out one cycle later on a registered valid/ready output. The output stage holds one result. The input is ready whenever that stage is empty or is being drained in the same cycle. When the consumer holds `out_ready` low on a valid result, the result stays frozen and `in_ready` drops, so the stall reaches the producer with no extra buffering.

Coordinates are measured from the start of memory. Within a tile, a subtile whose local y is below 16 is called bottom, and one whose local x is below 16 is called left.

Top module: `tformat_addr_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0.
- R2: A request accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_addr` right after that edge. When nothing is accepted and the held result is drained, `out_valid` goes low.
- R3: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_valid` hold, and `in_ready` is low.
- R4: Inside a micro-tile, pixels are in raster order. The byte offset contributed is (y mod 4)*16 + (x mod 4)*4.
- R5: Inside a subtile, micro-tiles are in raster order. The micro-tile index is ((y/4) mod 4)*4 + ((x/4) mod 4), and each index step adds 64 bytes.
- R6: In an even tile row, the subtile slots are as follows. Bottom-left is slot 0, top-left is slot 1, top-right is slot 2 and bottom-right is slot 3. Each slot adds 1024 bytes.
- R7: In an odd tile row, the subtile slots are as follows. Top-right is slot 0, bottom-right is slot 1, bottom-left is slot 2 and top-left is slot 3.
- R8: In an even tile row, the tile column stored is x/32.
- R9: In an odd tile row, the tile column stored is width_tiles-1-x/32.
- R10: The address is base + ((y/32)*width_tiles + column)*4096, plus the subtile, micro-tile and pixel offsets.
- R11: Pixel (0,0) maps exactly to the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge if valid |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row, counted from the start of memory |
| width_tiles | input | 8 | Surface width in 4 KB tiles |
| base_addr | input | 32 | Byte address of the surface |
| out_valid | output | 1 | Address result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_addr | output | 32 | Byte address of the pixel |

## Verification
Directed points each move one coordinate field at a time, so that each address term is tested on its own. The pixel bits within a micro-tile are one such field. Others are the micro-tile bits, the subtile quadrant in an even and in an odd tile row, and the tile column in both row directions. The tile row is also varied under two surface widths. A wrong slot order, a missing column mirror or a swapped stride shows up in a single compare.

A random sweep then changes width, coordinate and base together. Consumer readiness is toggled during the sweep, so that frozen results and a blocked input are compared against a scoreboard of addresses computed in the bench. A directed case with the consumer always ready pins down the one-cycle latency.

// File: rtl/tformat_pkg.sv
package tformat_pkg;
  // geometry of the layout, expressed as log2 quantities
  localparam int BPP_LOG2       = 2;  // 4 bytes per pixel
  localparam int UT_DIM_LOG2    = 2;  // micro-tile is 4x4 pixels
  localparam int ST_UT_LOG2     = 2;  // subtile is 4x4 micro-tiles
  localparam int TILE_ST_LOG2   = 1;  // tile is 2x2 subtiles

  localparam int ST_DIM_LOG2    = UT_DIM_LOG2 + ST_UT_LOG2;
  localparam int TILE_DIM_LOG2  = ST_DIM_LOG2 + TILE_ST_LOG2;
  localparam int UT_BYTES_LOG2  = BPP_LOG2 + 2 * UT_DIM_LOG2;
  localparam int ST_BYTES_LOG2  = UT_BYTES_LOG2 + 2 * ST_UT_LOG2;
  localparam int TILE_BYTES_LOG2 = ST_BYTES_LOG2 + 2 * TILE_ST_LOG2;

  typedef logic [2*TILE_ST_LOG2-1:0] slot_t;
endpackage

// File: rtl/tf_tile_locator.sv
module tf_tile_locator
  import tformat_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int Y_W    = 12,
  parameter int WT_W   = 8,
  parameter int ADDR_W = 32
) (
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic [WT_W-1:0]   width_tiles,
  output logic [ADDR_W-1:0] tile_off,
  output logic              odd_row
);
  localparam int TX_W = X_W - TILE_DIM_LOG2;
  localparam int TY_W = Y_W - TILE_DIM_LOG2;

  logic [TX_W-1:0]   tile_x;
  logic [TY_W-1:0]   tile_y;
  logic [WT_W-1:0]   col;
  logic [ADDR_W-1:0] tile_idx;

  always_comb begin
    tile_x  = pix_x[X_W-1:TILE_DIM_LOG2];
    tile_y  = pix_y[Y_W-1:TILE_DIM_LOG2];
    odd_row = tile_y[0];
    // serpentine: odd rows are mirrored across the surface width
    if (odd_row) col = width_tiles - WT_W'(1) - WT_W'(tile_x);
    else         col = WT_W'(tile_x);
    tile_idx = ADDR_W'(tile_y) * ADDR_W'(width_tiles) + ADDR_W'(col);
    tile_off = tile_idx << TILE_BYTES_LOG2;
  end
endmodule

// File: rtl/tf_subtile_order.sv
module tf_subtile_order
  import tformat_pkg::*;
(
  input  logic  right,    // local x in upper half of tile
  input  logic  top,      // local y in upper half of tile
  input  logic  odd_row,
  output slot_t slot
);
  // even row walk: BL, TL, TR, BR ; odd row walk is the same walk
  // rotated by two positions: TR, BR, BL, TL
  always_comb begin
    slot = {right ^ odd_row, right ^ top};
  end
endmodule

// File: rtl/tf_intra_offset.sv
module tf_intra_offset
  import tformat_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic [X_W-1:0]           pix_x,
  input  logic [Y_W-1:0]           pix_y,
  output logic [ST_BYTES_LOG2-1:0] off
);
  // raster micro-tile inside the subtile, raster pixel inside the micro-tile
  logic [ST_UT_LOG2-1:0]  ut_col, ut_row;
  logic [UT_DIM_LOG2-1:0] px, py;

  always_comb begin
    px     = pix_x[UT_DIM_LOG2-1:0];
    py     = pix_y[UT_DIM_LOG2-1:0];
    ut_col = pix_x[ST_DIM_LOG2-1:UT_DIM_LOG2];
    ut_row = pix_y[ST_DIM_LOG2-1:UT_DIM_LOG2];
    off    = {ut_row, ut_col, py, px, {BPP_LOG2{1'b0}}};
  end
endmodule

// File: rtl/tformat_addr_gen.sv
module tformat_addr_gen
  import tformat_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int Y_W    = 12,
  parameter int WT_W   = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic [WT_W-1:0]   width_tiles,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0]        tile_off;
  logic                     odd_row;
  slot_t                    slot;
  logic [ST_BYTES_LOG2-1:0] intra;
  logic [ADDR_W-1:0]        addr_c;
  logic                     take;

  tf_tile_locator #(
    .X_W(X_W), .Y_W(Y_W), .WT_W(WT_W), .ADDR_W(ADDR_W)
  ) u_loc (
    .pix_x(pix_x), .pix_y(pix_y), .width_tiles(width_tiles),
    .tile_off(tile_off), .odd_row(odd_row)
  );

  tf_subtile_order u_ord (
    .right(pix_x[ST_DIM_LOG2]), .top(pix_y[ST_DIM_LOG2]),
    .odd_row(odd_row), .slot(slot)
  );

  tf_intra_offset #(.X_W(X_W), .Y_W(Y_W)) u_intra (
    .pix_x(pix_x), .pix_y(pix_y), .off(intra)
  );

  always_comb begin
    addr_c = base_addr + tile_off
           + (ADDR_W'(slot) << ST_BYTES_LOG2)
           + ADDR_W'(intra);
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= addr_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tformat_addr_gen_chk.sv
module tformat_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_drain_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && out_ready |=> !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  assert_block_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind tformat_addr_gen tformat_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/tb_tformat_addr_gen.sv
module tb_tformat_addr_gen;
  localparam int X_W = 12, Y_W = 12, WT_W = 8, ADDR_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [X_W-1:0]    pix_x = '0;
  logic [Y_W-1:0]    pix_y = '0;
  logic [WT_W-1:0]   width_tiles = 8'd4;
  logic [ADDR_W-1:0] base_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [ADDR_W-1:0] out_addr;

  tformat_addr_gen #(.X_W(X_W), .Y_W(Y_W), .WT_W(WT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .pix_x(pix_x), .pix_y(pix_y), .width_tiles(width_tiles),
    .base_addr(base_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit rand_ready = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(int px, int py, int w, logic [31:0] b);
    int ty = py / 32;
    int tx = px / 32;
    int rx = (px % 32) / 16;
    int ry = (py % 32) / 16;
    int col, slot, ut;
    bit odd = (ty % 2) == 1;
    col = odd ? (w - 1 - tx) : tx;
    if (!odd)
      slot = (rx == 0 && ry == 0) ? 0 : (rx == 0 && ry == 1) ? 1 :
             (rx == 1 && ry == 1) ? 2 : 3;
    else
      slot = (rx == 1 && ry == 1) ? 0 : (rx == 1 && ry == 0) ? 1 :
             (rx == 0 && ry == 0) ? 2 : 3;
    ut = ((py / 4) % 4) * 4 + (px / 4) % 4;
    return b + 32'((ty * w + col) * 4096 + slot * 1024 + ut * 64
                   + (py % 4) * 16 + (px % 4) * 4);
  endfunction

  task automatic send(int px, int py, int w, logic [31:0] b, string tag);
    @(negedge clk);
    in_valid    = 1'b1;
    pix_x       = X_W'(px);
    pix_y       = Y_W'(py);
    width_tiles = WT_W'(w);
    base_addr   = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    exp_q.push_back(model(px, py, w, b));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard, plus consumer readiness
  bit          held = 1'b0;
  logic [31:0] held_addr;
  always @(negedge clk) begin
    if (!rst) begin
      out_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (held) begin
        check(out_valid === 1'b1 && out_addr === held_addr, "R3 hold",
              out_addr, held_addr);
      end
      if (out_valid && !out_ready) begin
        check(in_ready === 1'b0, "R3 in_ready", {31'd0, in_ready}, 32'd0);
        held      = 1'b1;
        held_addr = out_addr;
      end else begin
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 spurious", out_addr, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_addr === e, t, out_addr, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [31:0] B;
    B = 32'h1000_0000;
    // R1: valid stays low in reset even with requests offered
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 in reset", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    #3;
    check(out_valid === 1'b0, "R1 after reset", {31'd0, out_valid}, 32'd0);

    // R2: one-cycle latency with always-ready consumer
    send(0, 0, 4, B, "R11 origin");
    @(negedge clk);
    #3;
    check(out_valid === 1'b1, "R2 latency", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    #3;
    check(out_valid === 1'b0, "R2 drain", {31'd0, out_valid}, 32'd0);

    send(3, 2, 4, B, "R4 pixel in micro-tile");
    send(1, 3, 4, B, "R4 pixel in micro-tile");
    send(8, 12, 4, B, "R5 micro-tile index");
    send(12, 4, 4, B, "R5 micro-tile index");
    send(0, 16, 4, B, "R6 even top-left");
    send(16, 16, 4, B, "R6 even top-right");
    send(16, 0, 4, B, "R6 even bottom-right");
    send(16, 48, 4, B, "R7 odd top-right");
    send(16, 32, 4, B, "R7 odd bottom-right");
    send(0, 32, 4, B, "R7 odd bottom-left");
    send(0, 48, 4, B, "R7 odd top-left");
    send(40, 0, 4, B, "R8 even column");
    send(127, 0, 4, B, "R8 even last column");
    send(40, 32, 4, B, "R9 odd column mirrored");
    send(100, 32, 4, B, "R9 odd last column");
    send(0, 64, 4, B, "R10 row stride");
    send(70, 96, 7, B, "R10 row stride width 7");
    send(0, 0, 7, 32'h0000_4000, "R11 origin other base");

    // random sweep with back-pressure
    rand_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int w;
      w = 1 + int'($urandom % 20);
      send(int'($urandom % (w * 32)), int'($urandom % 4096), w,
           $urandom, "R10 random");
    end
    rand_ready = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule